// File: doc/BRIEF.md
# PoE Port Power Budget Arbiter

This block decides which Power over Ethernet ports may draw power from a shared supply of limited size. Each port reports whether a powered device is asking for power, its two-bit class code, its measured draw and two event flags (device removed, port overloaded). The block compares the measured draw of all powered ports against a provided-power budget. It admits new ports while a 15% reserve remains and sheds ports in priority order when the supply is over-committed.

All power values are unsigned fixed-point numbers in units of 0.1 W. The block evaluates once per clock. Decisions are taken from the registered port states and the inputs present before the edge, and they show at the outputs one cycle later. Every port holds one of four states: idle, powered, waiting for budget, or locked out after an overload. All pins are plain control and status levels. No data stream passes through the block, so it has no handshake and applies no back-pressure.

Top module: `pwr_budget_arbiter`

## Requirements
- R1: A candidate's requested power is 40 for class code 0, 70 for code 1, 154 for code 2, and for code 3 either 300 (port index below the 30 W count) or 154 (otherwise).
- R2: The total is the sum of the measured draw of existing powered ports only. When the total does not exceed the budget, the lowest-numbered candidate (an idle port with its request high, or any waiting port) is powered on the next cycle if total plus its request is at most floor(budget*85/100). At most one port is admitted per cycle.
- R3: When the total exceeds the budget but not the flood limit, exactly one powered port moves to waiting: the highest-numbered low-priority powered port, or, if there is none, the highest-numbered high-priority powered port. No admission happens in that cycle.
- R4: When the total exceeds the flood limit budget + floor(budget/10), every low-priority powered port moves to waiting in the same cycle, and high-priority ports keep power.
- R5: A powered port whose overload flag is high becomes locked (status 3). It stays locked regardless of its request until its unplug flag is seen.
- R6: An unplug flag returns its port to idle on the next cycle from any state, and it overrides every other decision for that port.
- R7: When a high-priority candidate does not fit and a low-priority port is powered, the highest-numbered powered low-priority port is shed in the same cycle and the candidate waits.
- R8: A candidate that does not fit moves to waiting (status 2). Waiting ports are candidates again on every cycle without needing their request.
- R9: When the all-ports input is low, only the lower half of the ports exist. Upper-half ports are forced idle, are not counted in the total and are never admitted.
- R10: Status per port is 2 bits at [2i+1:2i]: 0 idle, 1 powered, 2 waiting, 3 locked. The powered output bit i is high exactly when the status is 1. Reset leaves every port idle.
- R11: Ports with index below the high-priority count are high priority. Both the high-priority count and the 30 W count saturate at the number of ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| budget_i | input | PW | Provided power, 0.1 W units |
| hi_cnt_i | input | CW | Number of high-priority ports |
| plus_cnt_i | input | CW | Number of 30 W-capable ports |
| all_ports_i | input | 1 | 1: all ports exist; 0: lower half only |
| req_i | input | NPORT | Per-port device requesting power |
| cls_i | input | 2*NPORT | Per-port class code, port i at [2i+1:2i] |
| meas_i | input | PW*NPORT | Per-port measured draw, port i at [PW*i+PW-1:PW*i] |
| unplug_i | input | NPORT | Per-port device removed (open circuit) |
| ovl_i | input | NPORT | Per-port overload detected |
| on_o | output | NPORT | Per-port power granted |
| status_o | output | 2*NPORT | Per-port state code |

## Verification
A port event and a budget decision can fall in the same cycle. An unplug or overload flag can arrive on the very port that shedding or admission selects in that cycle. The random sweep raises the event flags sparsely while the draw swings through, under and above both limits, so such collisions recur under every priority and 30 W configuration. A directed case also unplugs a locked port while its request is high. A cycle-by-cycle model in the bench applies unplug first, then overload, then the shed or grant. It does not move a consumed shed to another port, and every status and power bit is compared against it after each edge.

// File: rtl/pwr_arb_pkg.sv
package pwr_arb_pkg;

  localparam int PWR_W = 16;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_ON   = 2'd1,
    PS_WAIT = 2'd2,
    PS_LOCK = 2'd3
  } pstate_t;

  // requested power for a class code, 0.1 W units
  function automatic logic [PWR_W-1:0] class_req(input logic [1:0] code, input logic plus_ok);
    logic [PWR_W-1:0] r;
    case (code)
      2'd0:    r = PWR_W'(40);
      2'd1:    r = PWR_W'(70);
      2'd2:    r = PWR_W'(154);
      default: r = plus_ok ? PWR_W'(300) : PWR_W'(154);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwr_meter.sv
module pwr_meter #(
  parameter int NPORT = 8,
  parameter int PW    = 16,
  parameter int AW    = PW + 8
) (
  input  logic [NPORT-1:0]    on_i,
  input  logic [PW*NPORT-1:0] meas_i,
  input  logic [PW-1:0]       budget_i,
  output logic [AW-1:0]       total_o,
  output logic [AW-1:0]       t85_o,
  output logic                over_o,
  output logic                flood_o
);

  logic [AW-1:0] t110;

  always_comb begin
    total_o = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (on_i[i]) total_o = total_o + AW'(meas_i[PW*i +: PW]);
    end
  end

  assign t85_o   = (AW'(budget_i) * AW'(85)) / AW'(100);
  assign t110    = AW'(budget_i) + AW'(budget_i) / AW'(10);
  assign over_o  = total_o > AW'(budget_i);
  assign flood_o = total_o > t110;

endmodule

// File: rtl/pwr_pick.sv
module pwr_pick #(
  parameter int NPORT = 8
) (
  input  logic [NPORT-1:0] on_i,
  input  logic [NPORT-1:0] low_on_i,
  input  logic [NPORT-1:0] cand_i,
  output logic [NPORT-1:0] shed_oh_o,
  output logic [NPORT-1:0] low_oh_o,
  output logic [NPORT-1:0] cand_oh_o
);

  logic [NPORT-1:0] hi_oh;

  // highest-numbered set bit wins for shedding
  always_comb begin
    low_oh_o = '0;
    hi_oh    = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (low_on_i[i]) begin
        low_oh_o    = '0;
        low_oh_o[i] = 1'b1;
      end
      if (on_i[i]) begin
        hi_oh    = '0;
        hi_oh[i] = 1'b1;
      end
    end
  end

  assign shed_oh_o = (|low_on_i) ? low_oh_o : hi_oh;

  // lowest-numbered candidate wins for admission
  always_comb begin
    cand_oh_o = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        cand_oh_o    = '0;
        cand_oh_o[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwr_port.sv
module pwr_port
  import pwr_arb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    exists_i,
  input  logic    unplug_i,
  input  logic    ovl_i,
  input  logic    go_on_i,
  input  logic    go_wait_i,
  output pstate_t state_o
);

  pstate_t nx;

  always_comb begin
    nx = state_o;
    if (!exists_i || unplug_i)            nx = PS_IDLE;
    else if (state_o == PS_ON && ovl_i)   nx = PS_LOCK;
    else if (go_on_i)                     nx = PS_ON;
    else if (go_wait_i)                   nx = PS_WAIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_o <= PS_IDLE;
    else        state_o <= nx;
  end

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_LOCK && exists_i && !unplug_i) |=> state_o == PS_LOCK)
    else $error("lock released without unplug");

  p_unplug_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unplug_i |=> state_o == PS_IDLE)
    else $error("unplug did not idle the port");

endmodule

// File: rtl/pwr_budget_arbiter.sv
module pwr_budget_arbiter
  import pwr_arb_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int PW    = PWR_W,
  parameter int CW    = $clog2(NPORT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PW-1:0]       budget_i,
  input  logic [CW-1:0]       hi_cnt_i,
  input  logic [CW-1:0]       plus_cnt_i,
  input  logic                all_ports_i,
  input  logic [NPORT-1:0]    req_i,
  input  logic [2*NPORT-1:0]  cls_i,
  input  logic [PW*NPORT-1:0] meas_i,
  input  logic [NPORT-1:0]    unplug_i,
  input  logic [NPORT-1:0]    ovl_i,
  output logic [NPORT-1:0]    on_o,
  output logic [2*NPORT-1:0]  status_o
);

  localparam int AW = PW + 8;

  pstate_t          st [NPORT];
  logic [NPORT-1:0] exists, himask, plusmask;
  logic [NPORT-1:0] on_vec, wait_vec, idle_vec, on_eff, low_on, cand_vec;
  logic [NPORT-1:0] shed_oh, low_oh, cand_oh, go_on, go_wait;
  logic [CW-1:0]    hi_eff, plus_eff;
  logic [AW-1:0]    total, t85, cand_req;
  logic             over, flood, fits, cand_any, cand_hi;

  assign hi_eff   = (hi_cnt_i   > CW'(NPORT)) ? CW'(NPORT) : hi_cnt_i;
  assign plus_eff = (plus_cnt_i > CW'(NPORT)) ? CW'(NPORT) : plus_cnt_i;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign exists[g]   = all_ports_i || (g < NPORT / 2);
    assign himask[g]   = CW'(g) < hi_eff;
    assign plusmask[g] = CW'(g) < plus_eff;
    assign on_vec[g]   = st[g] == PS_ON;
    assign wait_vec[g] = st[g] == PS_WAIT;
    assign idle_vec[g] = st[g] == PS_IDLE;
    assign status_o[2*g +: 2] = st[g];

    pwr_port u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .exists_i  (exists[g]),
      .unplug_i  (unplug_i[g]),
      .ovl_i     (ovl_i[g]),
      .go_on_i   (go_on[g]),
      .go_wait_i (go_wait[g]),
      .state_o   (st[g])
    );
  end

  assign on_o     = on_vec;
  assign on_eff   = on_vec & exists;
  assign low_on   = on_eff & ~himask;
  assign cand_vec = exists & ((idle_vec & req_i) | wait_vec);

  pwr_meter #(.NPORT(NPORT), .PW(PW), .AW(AW)) u_meter (
    .on_i     (on_eff),
    .meas_i   (meas_i),
    .budget_i (budget_i),
    .total_o  (total),
    .t85_o    (t85),
    .over_o   (over),
    .flood_o  (flood)
  );

  pwr_pick #(.NPORT(NPORT)) u_pick (
    .on_i      (on_eff),
    .low_on_i  (low_on),
    .cand_i    (cand_vec),
    .shed_oh_o (shed_oh),
    .low_oh_o  (low_oh),
    .cand_oh_o (cand_oh)
  );

  always_comb begin
    cand_req = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (cand_oh[i]) cand_req = AW'(class_req(cls_i[2*i +: 2], plusmask[i]));
    end
  end

  assign cand_any = |cand_vec;
  assign cand_hi  = |(cand_oh & himask);
  assign fits     = (total + cand_req) <= t85;

  // one decision class per cycle: flood, single shed, or one admission
  always_comb begin
    go_on   = '0;
    go_wait = '0;
    if (flood) begin
      go_wait = low_on;
    end else if (over) begin
      go_wait = shed_oh;
    end else if (cand_any) begin
      if (fits) go_on = cand_oh;
      else      go_wait = cand_oh | (cand_hi ? low_oh : '0);
    end
  end

  p_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!over && !fits) |=> ((on_vec & ~$past(on_eff)) == '0))
    else $error("port admitted beyond the reserve");

  p_one_shed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !flood) |=> $countones($past(on_eff) & wait_vec) <= 1)
    else $error("more than one port shed");

  p_flood_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flood |=> ((on_vec & ~$past(himask)) == '0))
    else $error("low-priority port still on after flood");

  p_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ports_i |=> on_vec[NPORT-1:NPORT/2] == '0)
    else $error("absent port powered");

endmodule

// File: tb/tb_pwr_budget_arbiter.sv
`timescale 1ns/1ps
module tb_pwr_budget_arbiter;

  localparam int N  = 8;
  localparam int PW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PW-1:0]   budget = 16'd1000;
  logic [3:0]      hi_cnt = 4'd2, plus_cnt = 4'd1;
  logic            all_ports = 1'b1;
  logic [N-1:0]    req = '0, unplug = '0, ovl = '0;
  logic [2*N-1:0]  cls = '0;
  logic [PW*N-1:0] meas = '0;
  logic [N-1:0]    on_o;
  logic [2*N-1:0]  status_o;

  logic [1:0] m_st [N];
  logic [1:0] m_nx [N];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_budget_arbiter dut (
    .clk(clk), .rst_n(rst_n), .budget_i(budget), .hi_cnt_i(hi_cnt),
    .plus_cnt_i(plus_cnt), .all_ports_i(all_ports), .req_i(req), .cls_i(cls),
    .meas_i(meas), .unplug_i(unplug), .ovl_i(ovl), .on_o(on_o), .status_o(status_o)
  );

  function automatic int class_w(input logic [1:0] c, input bit plus);
    if (c == 2'd0) return 40;
    if (c == 2'd1) return 70;
    if (c == 2'd2) return 154;
    return plus ? 300 : 154;
  endfunction

  // reference: next state of every port from requirement text
  task automatic model_next();
    int np, hi, pl, tot, t85, t110, cand, vic;
    np  = all_ports ? N : N / 2;
    hi  = (int'(hi_cnt) > N) ? N : int'(hi_cnt);
    pl  = (int'(plus_cnt) > N) ? N : int'(plus_cnt);
    tot = 0;
    for (int i = 0; i < np; i++) if (m_st[i] == 2'd1) tot += int'(meas[PW*i +: PW]);
    t85  = (int'(budget) * 85) / 100;
    t110 = int'(budget) + int'(budget) / 10;
    for (int i = 0; i < N; i++) m_nx[i] = (i < np) ? m_st[i] : 2'd0;
    if (tot > t110) begin
      for (int i = hi; i < np; i++) if (m_st[i] == 2'd1) m_nx[i] = 2'd2;
    end else if (tot > int'(budget)) begin
      vic = -1;
      for (int i = hi; i < np; i++) if (m_st[i] == 2'd1) vic = i;
      if (vic < 0) for (int i = 0; i < np; i++) if (m_st[i] == 2'd1) vic = i;
      if (vic >= 0) m_nx[vic] = 2'd2;
    end else begin
      cand = -1;
      for (int i = np - 1; i >= 0; i--)
        if ((m_st[i] == 2'd0 && req[i]) || m_st[i] == 2'd2) cand = i;
      if (cand >= 0) begin
        if (tot + class_w(cls[2*cand +: 2], cand < pl) <= t85) m_nx[cand] = 2'd1;
        else begin
          m_nx[cand] = 2'd2;
          if (cand < hi) begin
            vic = -1;
            for (int i = hi; i < np; i++) if (m_st[i] == 2'd1) vic = i;
            if (vic >= 0) m_nx[vic] = 2'd2;
          end
        end
      end
    end
    for (int i = 0; i < np; i++) begin
      if (m_st[i] == 2'd1 && ovl[i]) m_nx[i] = 2'd3;
      if (unplug[i]) m_nx[i] = 2'd0;
    end
  endtask

  task automatic compare(input string tag);
    logic [2*N-1:0] es;
    logic [N-1:0]   eo;
    for (int i = 0; i < N; i++) begin
      es[2*i +: 2] = m_st[i];
      eo[i] = (m_st[i] == 2'd1);
    end
    n_chk++;
    if (status_o !== es) begin
      n_bad++;
      $display("FAIL %s status act=%h exp=%h t=%0t", tag, status_o, es, $time);
    end
    n_chk++;
    if (on_o !== eo) begin
      n_bad++;
      $display("FAIL %s on act=%h exp=%h t=%0t", tag, on_o, eo, $time);
    end
  endtask

  task automatic step_chk(input string tag);
    model_next();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) m_st[i] = m_nx[i];
    compare(tag);
  endtask

  task automatic set_port(input int i, input logic [1:0] c, input int w);
    cls[2*i +: 2]  = c;
    meas[PW*i +: PW] = PW'(w);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int hv [4] = '{0, 3, 8, 12};
    int pv [3] = '{0, 5, 9};
    for (int i = 0; i < N; i++) m_st[i] = 2'd0;
    repeat (3) @(negedge clk);
    compare("R10 reset idle");
    rst_n = 1'b1;

    // R2: two requests, one admission per cycle, lowest first
    set_port(0, 2'd2, 0); set_port(1, 2'd0, 0);
    req = 8'b0000_0011;
    step_chk("R2 first grant");
    step_chk("R2 second grant");
    req = '0;

    // R1: class 3 on a non-30W port asks 154, on a 30W port asks 300
    set_port(0, 2'd2, 600);
    set_port(2, 2'd3, 0); req[2] = 1'b1;
    step_chk("R1 class3 as 154");
    plus_cnt = 4'd4;
    set_port(3, 2'd3, 0); req[3] = 1'b1; req[2] = 1'b0;
    step_chk("R1 class3 as 300 denied");
    req[3] = 1'b0;
    step_chk("R8 waiting stays");
    set_port(0, 2'd2, 400);
    step_chk("R8 waiting retried");

    // R4: flood sheds all low-priority ports at once
    set_port(0, 2'd2, 100); set_port(1, 2'd0, 100);
    set_port(2, 2'd3, 500); set_port(3, 2'd3, 450);
    step_chk("R4 flood");
    set_port(2, 2'd3, 0); set_port(3, 2'd3, 0);
    step_chk("R8 regrant a");
    step_chk("R8 regrant b");

    // R3: single sheds, low first then high
    set_port(0, 2'd2, 300); set_port(1, 2'd0, 300);
    set_port(2, 2'd3, 250); set_port(3, 2'd3, 200);
    step_chk("R3 shed highest low");
    step_chk("R3 no admission above reserve");
    set_port(2, 2'd3, 500);
    step_chk("R3 shed next low");
    set_port(0, 2'd2, 700); set_port(1, 2'd0, 600);
    step_chk("R4 high ports kept");
    set_port(0, 2'd2, 600); set_port(1, 2'd0, 500);
    step_chk("R3 shed high after lows");

    // R5/R6: overload lock and release by unplug
    for (int i = 0; i < 4; i++) meas[PW*i +: PW] = '0;
    ovl[0] = 1'b1; req[0] = 1'b1;
    step_chk("R5 overload locks");
    ovl[0] = 1'b0;
    repeat (3) step_chk("R5 lock held with request");
    unplug[0] = 1'b1;
    step_chk("R6 unplug releases lock");
    unplug[0] = 1'b0; req[0] = 1'b0;

    // R7: high-priority candidate makes room
    set_port(1, 2'd0, 100); set_port(2, 2'd3, 300); set_port(3, 2'd3, 300);
    set_port(0, 2'd2, 0); req[0] = 1'b1;
    step_chk("R7 shed low for high");
    step_chk("R7 high granted later");
    req[0] = 1'b0;

    // R11: saturated counts
    hi_cnt = 4'd12; plus_cnt = 4'd15;
    set_port(0, 2'd2, 400); set_port(1, 2'd0, 400); set_port(2, 2'd3, 300);
    step_chk("R11 saturated priority shed");
    hi_cnt = 4'd2; plus_cnt = 4'd4;

    // R9: half-port mode
    for (int i = 0; i < N; i++) meas[PW*i +: PW] = '0;
    set_port(4, 2'd0, 50); req[4] = 1'b1;
    repeat (4) step_chk("R9 upper port admitted in full mode");
    req[4] = 1'b0;
    all_ports = 1'b0; req[5] = 1'b1;
    step_chk("R9 upper port dropped");
    step_chk("R9 upper request ignored");
    all_ports = 1'b1; req = '0;

    // near-exhaustive sweep of configurations with random traffic
    for (int e = 0; e < 2; e++)
      for (int h = 0; h < 4; h++)
        for (int p = 0; p < 3; p++) begin
          all_ports = (e == 1);
          hi_cnt    = 4'(hv[h]);
          plus_cnt  = 4'(pv[p]);
          budget    = 16'($urandom_range(300, 2000));
          repeat (250) begin
            req = 8'($urandom);
            cls = 16'($urandom);
            for (int i = 0; i < N; i++) begin
              meas[PW*i +: PW] = 16'($urandom_range(0, 400));
              unplug[i] = ($urandom_range(0, 15) == 0);
              ovl[i]    = ($urandom_range(0, 23) == 0);
            end
            step_chk("R2/R3/R4/R5/R6/R8 sweep");
          end
        end

    done = 1;
    summary();
    $finish;
  end

endmodule